// File: doc/BRIEF.md
# Virtual-Channel Input Port with Table Routing

This block is the receive half of one port of a wormhole-switched on-chip network switch. Flits arrive one per cycle, each tagged with a virtual-channel number. They are held in a small FIFO for that channel. When a packet's first flit arrives, its destination is used as the index into a programmable forwarding table. The table gives the output port on the precomputed shortest path to that destination. Only the leading flit performs this lookup. The chosen output is held for the rest of the packet and released when the closing flit leaves the port.

For each channel, the port presents the flit at the head of its FIFO together with the output it must take. A switch allocator outside this block grants at most one channel per cycle. Each flit removed by a grant returns one credit to the upstream switch. The forwarding table is filled through a simple write port. A write affects only packets whose leading flit arrives after the write, and routes already held are left unchanged. A flit that arrives for a full channel is dropped, and so is a body or tail flit that arrives for a channel with no open packet. Either case sets a sticky error flag.

Top module: `wh_input_port`

## Requirements
- R1: After reset every channel is empty (no request is raised), the error flag and credit output are low, and every table entry holds output port 0.
- R2: Flit kind is a 2-bit code: 00 header, 01 body, 10 tail, 11 single-flit packet. For a header or single-flit packet, the destination is the low log2(NUM_DEST) payload bits. When that flit is at the head of its channel, the requested port equals the table entry for that destination as it stood in the flit's arrival cycle.
- R3: Body and tail flits request the port of their packet's header, even when the table has been rewritten since that header arrived.
- R4: When a tail or single-flit packet leaves, the held route is released. The next header on that channel performs a fresh lookup.
- R5: A table write in the same cycle as a header's arrival is not seen by that header. It is seen by headers that arrive in later cycles.
- R6: Each granted, non-empty channel removes its head flit. One cycle later credit_valid is high, with credit_vc naming that channel.
- R7: Each channel is a FIFO of VC_DEPTH flits. A flit appears at the head output in the cycle after it is written, and flits on one channel leave in arrival order.
- R8: A flit that arrives for a channel already holding VC_DEPTH flits at the start of that cycle is dropped, even if that channel is also granted in the same cycle, and the error flag is set and stays set.
- R9: A body or tail flit that arrives for a channel with no open packet is dropped, and the error flag is set.
- R10: Channels are independent: packets interleaved flit by flit on different channels each keep their own route and order.
- R11: A grant to an empty channel has no effect and returns no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming flit valid |
| in_vc | input | VCW | Virtual channel of the incoming flit |
| in_kind | input | 2 | Flit kind code |
| in_data | input | FLIT_W | Flit payload; destination in low bits for headers |
| tbl_we | input | 1 | Forwarding table write enable |
| tbl_addr | input | DW | Destination entry to write |
| tbl_port | input | PW | Output port to store |
| grant | input | NUM_VC | One-hot-or-zero dequeue grant per channel |
| req_valid | output | NUM_VC | Channel holds a flit |
| req_port | output | NUM_VC*PW | Output port requested by each channel's head flit |
| req_kind | output | NUM_VC*2 | Kind of each channel's head flit |
| req_data | output | NUM_VC*FLIT_W | Payload of each channel's head flit |
| credit_valid | output | 1 | One credit returned to upstream |
| credit_vc | output | VCW | Channel the credit belongs to |
| err | output | 1 | Sticky drop error flag |

## Verification
The bench builds the port with four channels of four flits each, 16-bit flits, sixteen destinations and five output ports. With four-deep FIFOs, a channel fills after four writes, so overflow drops and simultaneous grant-and-write on a full channel come up often in random traffic. Sixteen destinations with five ports make table rewrites between a header and its tail change the looked-up port, which exposes any route that is not held. Four channels give enough interleaving to show mix-ups between channels.

// File: rtl/wh_pkg.sv
package wh_pkg;

    typedef enum logic [1:0] {
        FT_HEAD = 2'b00,
        FT_BODY = 2'b01,
        FT_TAIL = 2'b10,
        FT_SOLO = 2'b11
    } flit_kind_e;

    // true for flits that begin a packet and carry a destination
    function automatic logic starts_pkt(input flit_kind_e k);
        return (k == FT_HEAD) || (k == FT_SOLO);
    endfunction

    // true for flits that close a packet
    function automatic logic ends_pkt(input flit_kind_e k);
        return (k == FT_TAIL) || (k == FT_SOLO);
    endfunction

endpackage

// File: rtl/wh_vc_fifo.sv
module wh_vc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);

endmodule

// File: rtl/wh_route_table.sv
module wh_route_table #(
    parameter int NUM_DEST = 16,
    parameter int DW       = 4,
    parameter int PW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] waddr,
    input  logic [PW-1:0] wport,
    input  logic [DW-1:0] raddr,
    output logic [PW-1:0] rport
);
    logic [PW-1:0] entry [NUM_DEST];

    logic w_in_range, r_in_range;
    assign w_in_range = ({1'b0, waddr} < (DW+1)'(NUM_DEST));
    assign r_in_range = ({1'b0, raddr} < (DW+1)'(NUM_DEST));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_DEST; i++) entry[i] <= '0;
        end else if (we && w_in_range) begin
            entry[waddr] <= wport;
        end
    end

    // read sees the value before any write in the same cycle
    assign rport = r_in_range ? entry[raddr] : '0;

endmodule

// File: rtl/wh_vc_ctrl.sv
module wh_vc_ctrl
    import wh_pkg::*;
#(
    parameter int FLIT_W = 32,
    parameter int DEPTH  = 4,
    parameter int PW     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_valid,
    input  logic [1:0]        arr_kind,
    input  logic [FLIT_W-1:0] arr_data,
    input  logic [PW-1:0]     lookup_port,
    input  logic              deq,
    output logic              req_valid,
    output logic [1:0]        req_kind,
    output logic [FLIT_W-1:0] req_data,
    output logic [PW-1:0]     req_port,
    output logic              deq_done,
    output logic              err_full,
    output logic              err_orphan
);
    typedef struct packed {
        flit_kind_e        kind;
        logic [FLIT_W-1:0] data;
        logic [PW-1:0]     port;
    } slot_t;

    localparam int SW = $bits(slot_t);

    flit_kind_e    a_kind;
    slot_t         wr_slot, hd_slot;
    logic [SW-1:0] hd_bits;
    logic          full, empty, accept, pop;
    logic          in_open;
    logic          out_active;
    logic [PW-1:0] out_route;

    assign a_kind     = flit_kind_e'(arr_kind);
    assign err_full   = arr_valid && full;
    assign err_orphan = arr_valid && !full && !starts_pkt(a_kind) && !in_open;
    assign accept     = arr_valid && !full && (starts_pkt(a_kind) || in_open);
    assign pop        = deq && !empty;

    always_comb begin
        wr_slot.kind = a_kind;
        wr_slot.data = arr_data;
        wr_slot.port = starts_pkt(a_kind) ? lookup_port : '0;
    end

    wh_vc_fifo #(.W(SW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (accept),
        .wdata (wr_slot),
        .pop   (pop),
        .rdata (hd_bits),
        .empty (empty),
        .full  (full)
    );

    assign hd_slot = slot_t'(hd_bits);

    // arrival side: tracks whether a packet is open on this channel
    always_ff @(posedge clk) begin
        if (rst)         in_open <= 1'b0;
        else if (accept) in_open <= !ends_pkt(a_kind);
    end

    // departure side: route held from header departure to tail departure
    always_ff @(posedge clk) begin
        if (rst) begin
            out_active <= 1'b0;
            out_route  <= '0;
        end else if (pop) begin
            if (hd_slot.kind == FT_HEAD) begin
                out_active <= 1'b1;
                out_route  <= hd_slot.port;
            end else if (ends_pkt(hd_slot.kind)) begin
                out_active <= 1'b0;
            end
        end
    end

    assign req_valid = !empty;
    assign req_kind  = hd_slot.kind;
    assign req_data  = hd_slot.data;
    assign req_port  = starts_pkt(hd_slot.kind) ? hd_slot.port : out_route;
    assign deq_done  = pop;

    // R3
    body_route_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty && !starts_pkt(hd_slot.kind)) |-> out_active);
    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && full && !pop) |=> full);

endmodule

// File: rtl/wh_input_port.sv
module wh_input_port
    import wh_pkg::*;
#(
    parameter int FLIT_W   = 32,
    parameter int NUM_VC   = 8,
    parameter int VC_DEPTH = 4,
    parameter int NUM_DEST = 16,
    parameter int NUM_OUT  = 5,
    localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int DW  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    localparam int PW  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [VCW-1:0]           in_vc,
    input  logic [1:0]               in_kind,
    input  logic [FLIT_W-1:0]        in_data,
    input  logic                     tbl_we,
    input  logic [DW-1:0]            tbl_addr,
    input  logic [PW-1:0]            tbl_port,
    input  logic [NUM_VC-1:0]        grant,
    output logic [NUM_VC-1:0]        req_valid,
    output logic [NUM_VC*PW-1:0]     req_port,
    output logic [NUM_VC*2-1:0]      req_kind,
    output logic [NUM_VC*FLIT_W-1:0] req_data,
    output logic                     credit_valid,
    output logic [VCW-1:0]           credit_vc,
    output logic                     err
);
    logic [PW-1:0]     lookup_port;
    logic [NUM_VC-1:0] deq_done, err_full, err_orphan;
    logic              deq_any;
    logic [VCW-1:0]    deq_idx;

    wh_route_table #(.NUM_DEST(NUM_DEST), .DW(DW), .PW(PW)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wport (tbl_port),
        .raddr (in_data[DW-1:0]),
        .rport (lookup_port)
    );

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        wh_vc_ctrl #(.FLIT_W(FLIT_W), .DEPTH(VC_DEPTH), .PW(PW)) u_vc (
            .clk         (clk),
            .rst         (rst),
            .arr_valid   (in_valid && (in_vc == VCW'(v))),
            .arr_kind    (in_kind),
            .arr_data    (in_data),
            .lookup_port (lookup_port),
            .deq         (grant[v]),
            .req_valid   (req_valid[v]),
            .req_kind    (req_kind[v*2 +: 2]),
            .req_data    (req_data[v*FLIT_W +: FLIT_W]),
            .req_port    (req_port[v*PW +: PW]),
            .deq_done    (deq_done[v]),
            .err_full    (err_full[v]),
            .err_orphan  (err_orphan[v])
        );
    end

    always_comb begin
        deq_any = 1'b0;
        deq_idx = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (deq_done[v]) begin
                deq_any = 1'b1;
                deq_idx = VCW'(v);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_valid <= 1'b0;
            credit_vc    <= '0;
            err          <= 1'b0;
        end else begin
            credit_valid <= deq_any;
            credit_vc    <= deq_idx;
            err          <= err | (|err_full) | (|err_orphan);
        end
    end

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
    // R6
    credit_follow_chk: assert property (@(posedge clk) disable iff (rst)
        deq_any |=> (credit_valid && credit_vc == $past(deq_idx)));
    // R11
    no_spurious_credit_chk: assert property (@(posedge clk) disable iff (rst)
        !deq_any |=> !credit_valid);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);

endmodule

// File: tb/test_wh_input_port.sv
module test_wh_input_port;
    import wh_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV  = 4;
    localparam int FW  = 16;
    localparam int DEP = 4;
    localparam int ND  = 16;
    localparam int NO  = 5;
    localparam int VCW = 2;
    localparam int DW  = 4;
    localparam int PW  = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [VCW-1:0]    in_vc;
    logic [1:0]        in_kind;
    logic [FW-1:0]     in_data;
    logic              tbl_we;
    logic [DW-1:0]     tbl_addr;
    logic [PW-1:0]     tbl_port;
    logic [NV-1:0]     grant;
    logic [NV-1:0]     req_valid;
    logic [NV*PW-1:0]  req_port;
    logic [NV*2-1:0]   req_kind;
    logic [NV*FW-1:0]  req_data;
    logic              credit_valid;
    logic [VCW-1:0]    credit_vc;
    logic              err;

    wh_input_port #(.FLIT_W(FW), .NUM_VC(NV), .VC_DEPTH(DEP), .NUM_DEST(ND), .NUM_OUT(NO))
    i_wh_input_port (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vc(in_vc), .in_kind(in_kind),
        .in_data(in_data), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_port(tbl_port),
        .grant(grant), .req_valid(req_valid), .req_port(req_port), .req_kind(req_kind),
        .req_data(req_data), .credit_valid(credit_valid), .credit_vc(credit_vc), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model
    int          mq_n [NV];
    logic [1:0]  mq_k [NV][DEP];
    logic [FW-1:0] mq_d [NV][DEP];
    logic [PW-1:0] mq_p [NV][DEP];
    bit          m_open [NV];
    logic [PW-1:0] m_inport [NV];
    logic [PW-1:0] m_tbl [ND];
    bit          m_err;
    bit          e_cv;
    int          e_cvc;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [PW-1:0] port_of(input int v);
        return req_port[v*PW +: PW];
    endfunction

    function automatic bit m_starts(input logic [1:0] k);
        return (k == 2'b00) || (k == 2'b11);
    endfunction

    function automatic bit m_ends(input logic [1:0] k);
        return (k == 2'b10) || (k == 2'b11);
    endfunction

    task automatic model_reset();
        for (int v = 0; v < NV; v++) begin
            mq_n[v] = 0; m_open[v] = 1'b0; m_inport[v] = '0;
        end
        for (int d = 0; d < ND; d++) m_tbl[d] = '0;
        m_err = 1'b0; e_cv = 1'b0; e_cvc = 0;
    endtask

    task automatic check_all();
        for (int v = 0; v < NV; v++) begin
            chk("R7 valid", 32'(req_valid[v]), 32'(mq_n[v] > 0));
            if (mq_n[v] > 0) begin
                chk("R7 kind", 32'(req_kind[v*2 +: 2]), 32'(mq_k[v][0]));
                chk("R7 data", 32'(req_data[v*FW +: FW]), 32'(mq_d[v][0]));
                if (m_starts(mq_k[v][0])) chk("R2 port", 32'(port_of(v)), 32'(mq_p[v][0]));
                else                      chk("R3 port", 32'(port_of(v)), 32'(mq_p[v][0]));
            end
        end
        chk("R6 credit_valid", 32'(credit_valid), 32'(e_cv));
        if (e_cv) chk("R6 credit_vc", 32'(credit_vc), 32'(e_cvc));
        chk("R8 R9 err", 32'(err), 32'(m_err));
    endtask

    task automatic step(input bit iv, input int vc, input logic [1:0] k, input logic [FW-1:0] d,
                        input bit tw, input int ta, input int tp, input int gvc);
        bit g_eff, full0, acc;
        logic [PW-1:0] lk;
        @(negedge clk);
        in_valid = iv; in_vc = VCW'(vc); in_kind = k; in_data = d;
        tbl_we = tw; tbl_addr = DW'(ta); tbl_port = PW'(tp);
        grant = (gvc >= 0) ? NV'(1 << gvc) : '0;
        @(posedge clk);
        g_eff = (gvc >= 0) && (mq_n[gvc] > 0);
        full0 = iv && (mq_n[vc] == DEP);
        lk    = m_tbl[d[DW-1:0]];
        acc   = iv && !full0 && (m_starts(k) || m_open[vc]);
        if (iv && !acc) m_err = 1'b1;
        if (g_eff) begin
            for (int i = 0; i < DEP - 1; i++) begin
                mq_k[gvc][i] = mq_k[gvc][i+1];
                mq_d[gvc][i] = mq_d[gvc][i+1];
                mq_p[gvc][i] = mq_p[gvc][i+1];
            end
            mq_n[gvc]--;
        end
        if (acc) begin
            if (m_starts(k)) m_inport[vc] = lk;
            mq_k[vc][mq_n[vc]] = k;
            mq_d[vc][mq_n[vc]] = d;
            mq_p[vc][mq_n[vc]] = m_inport[vc];
            mq_n[vc]++;
            m_open[vc] = !m_ends(k);
        end
        if (tw) m_tbl[ta] = PW'(tp);
        e_cv = g_eff; e_cvc = gvc;
        #2;
        check_all();
    endtask

    task automatic idle(input int gvc);
        step(1'b0, 0, 2'b00, '0, 1'b0, 0, 0, gvc);
    endtask

    task automatic send(input int vc, input logic [1:0] k, input logic [FW-1:0] d);
        step(1'b1, vc, k, d, 1'b0, 0, 0, -1);
    endtask

    task automatic twrite(input int a, input int p);
        step(1'b0, 0, 2'b00, '0, 1'b1, a, p, -1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 0; tbl_we = 0; grant = '0;
        in_vc = '0; in_kind = '0; in_data = '0; tbl_addr = '0; tbl_port = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic drain();
        for (int v = 0; v < NV; v++)
            while (mq_n[v] > 0) idle(v);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        do_reset();
        #1;
        chk("R1 req_valid", 32'(req_valid), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 credit", 32'(credit_valid), 0);
        send(0, 2'b11, 16'h0009);
        chk("R1 table reset port", 32'(port_of(0)), 0);
        idle(0);

        // R2 / R5 table lookup and write timing
        twrite(3, 2);
        twrite(5, 4);
        step(1'b1, 0, 2'b00, 16'h0003, 1'b1, 3, 1, -1);
        chk("R5 same-cycle write unseen", 32'(port_of(0)), 2);
        send(1, 2'b00, 16'h0013);
        chk("R5 later header sees write", 32'(port_of(1)), 1);
        // R10 interleaved packets
        send(0, 2'b01, 16'hA001);
        send(1, 2'b01, 16'hB001);
        twrite(3, 3);
        send(0, 2'b10, 16'hA002);
        send(1, 2'b10, 16'hB002);
        idle(0);
        chk("R3 body keeps header route", 32'(port_of(0)), 2);
        chk("R10 other channel route", 32'(port_of(1)), 1);
        chk("R6 credit after grant", 32'(credit_valid), 1);
        idle(1);
        chk("R10 vc1 body port", 32'(port_of(1)), 1);
        idle(2);
        chk("R11 empty grant no credit", 32'(credit_valid), 0);
        drain();
        // R4 fresh lookup after tail left
        send(0, 2'b00, 16'h0003);
        chk("R4 new header new route", 32'(port_of(0)), 3);
        send(2, 2'b11, 16'h0005);
        chk("R2 single-flit lookup", 32'(port_of(2)), 4);
        send(0, 2'b10, 16'h00EE);
        drain();
        chk("R8 R9 no error so far", 32'(err), 0);

        // R9 orphan body
        send(3, 2'b01, 16'h0BAD);
        chk("R9 orphan sets err", 32'(err), 1);
        chk("R9 orphan dropped", 32'(req_valid[3]), 0);

        // R8 overflow, including grant in the same cycle
        do_reset();
        send(0, 2'b00, 16'h0001);
        send(0, 2'b01, 16'h1111);
        send(0, 2'b01, 16'h2222);
        send(0, 2'b01, 16'h3333);
        chk("R8 no error before full", 32'(err), 0);
        step(1'b1, 0, 2'b01, 16'h4444, 1'b0, 0, 0, 0);
        chk("R8 full drop sets err", 32'(err), 1);
        drain();

        // random traffic
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int vc, r, g;
            logic [1:0] k;
            vc = int'($urandom_range(NV - 1));
            r  = int'($urandom_range(99));
            if (!m_open[vc]) k = (r < 80) ? 2'b00 : ((r < 95) ? 2'b11 : 2'b01);
            else             k = (r < 65) ? 2'b01 : ((r < 95) ? 2'b10 : 2'b00);
            g = ($urandom_range(9) < 6) ? int'($urandom_range(NV - 1)) : -1;
            step($urandom_range(9) < 7, vc, k, FW'($urandom()),
                 $urandom_range(19) == 0, int'($urandom_range(ND - 1)),
                 int'($urandom_range(NO - 1)), g);
        end
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule